// File: doc/BRIEF.md
# Staged Reset Sequencer

This block turns a single raw, active-low power-on reset pin into three internal resets that come out of reset one after another. It runs from a free-running reference clock (nominally 24 MHz). The raw pin is first brought into the clock domain by a short synchroniser chain. It then passes a glitch filter, which accepts a low level only once it has been seen on several consecutive clock edges.

While an accepted low is present, all three outputs are held low. Once the pin goes high again, a single counter measures the time since release. The PLL reset is let go first, after about 5 µs (120 cycles). The chip-logic reset follows after about 139 µs (3336 cycles). The IP reset follows a fixed tail of 15 cycles after that, so that IP blocks see reset held for a known minimum span.

Every delay is a parameter counted in reference cycles. A test setup can shrink them, and an integration can retune them to another reference frequency. Edge numbering below counts the first rising clock edge at which the pin is sampled high (or low) as edge 1.

Top module: `reset_sequencer`

## Requirements
- R1: From time zero, with the pin held low, all three outputs are low (asserted), and they stay low until their release point is reached.
- R2: A low pulse on the pin that is sampled on no more than GLITCH_MAX consecutive edges (default 5) changes no output. It does not move the release timing of a sequence that is already in progress.
- R3: A low level sampled on GLITCH_MAX+1 consecutive edges is accepted. All three outputs go low together at edge GLITCH_MAX+4 of that low level.
- R4: After the pin goes high from an accepted low, pll_rst_n rises at edge PLL_DLY+3.
- R5: chip_rst_n rises at edge CHIP_DLY+3 after the pin goes high, which is after pll_rst_n.
- R6: ip_rst_n rises at edge CHIP_DLY+IP_TAIL+3 after the pin goes high, which is IP_TAIL cycles after chip_rst_n.
- R7: At no time is a later reset released while an earlier one is still held. If ip_rst_n is high, chip_rst_n is high; if chip_rst_n is high, pll_rst_n is high.
- R8: An accepted low that arrives part way through the sequence drives all outputs low again. The next release of the pin then restarts the full timing from its beginning.
- R9: Once all outputs are high, they stay high for as long as no low level is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Free-running reference clock (24 MHz nominal) |
| por_pin_n | input | 1 | Raw external power-on reset pin, active low, asynchronous |
| pll_rst_n | output | 1 | PLL reset, active low, released first |
| chip_rst_n | output | 1 | Chip-logic reset, active low, released second |
| ip_rst_n | output | 1 | IP reset, active low, released last |

## Verification
The bench aims at the filter threshold from both sides. A pulse of exactly GLITCH_MAX sampled lows must leave everything untouched, while one more low must reset all three outputs. A filter that is off by one would either drop the chip on a glitch or miss a legal reset. The bench times each release to the exact edge, so an extra or missing pipeline register, or a comparison of the wrong kind, shows up as an event one cycle early or late. A low pulse that arrives after the PLL release but before the chip release checks that the counter restarts rather than resumes. A short glitch in the same window checks that the timing is not disturbed, since a design that reset only part of the state would release at the wrong time.

// File: rtl/rs_pkg.sv
package rs_pkg;

    // Three active-low reset lines, in release order.
    typedef struct packed {
        logic pll_n;
        logic chip_n;
        logic ip_n;
    } rst_vec_t;

    localparam rst_vec_t RST_ALL_HELD = '{pll_n: 1'b0, chip_n: 1'b0, ip_n: 1'b0};

endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d;
    logic [STAGES-1:0] sync_q = '0;

    assign sync_d[0] = din;

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        assign sync_d[g] = sync_q[g-1];
    end

    always_ff @(posedge clk) begin
        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/rs_glitch_filter.sv
module rs_glitch_filter #(
    parameter int GLITCH_MAX = 5
) (
    input  logic clk,
    input  logic pin_n_sync,
    output logic hold
);
    localparam int ACCEPT = GLITCH_MAX + 1;
    localparam int CW     = $clog2(ACCEPT + 1);

    typedef struct packed {
        logic [CW-1:0] low_cnt;
        logic          hold;
    } flt_t;

    flt_t st_d;
    flt_t st_q = '{low_cnt: '0, hold: 1'b1};

    always_comb begin
        st_d = st_q;
        if (!pin_n_sync) begin
            if (st_q.low_cnt != CW'(ACCEPT)) begin
                st_d.low_cnt = st_q.low_cnt + CW'(1);
            end
            if (st_d.low_cnt == CW'(ACCEPT)) begin
                st_d.hold = 1'b1;
            end
        end else begin
            st_d.low_cnt = '0;
            st_d.hold    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign hold = st_q.hold;
endmodule

// File: rtl/rs_release_timer.sv
module rs_release_timer
    import rs_pkg::*;
#(
    parameter int PLL_DLY  = 120,
    parameter int CHIP_DLY = 3336,
    parameter int IP_TAIL  = 15
) (
    input  logic     clk,
    input  logic     hold,
    output rst_vec_t rst
);
    localparam int LAST = CHIP_DLY + IP_TAIL;
    localparam int CW   = $clog2(LAST + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        rst_vec_t      rst;
    } tmr_t;

    tmr_t st_d;
    tmr_t st_q = '0;

    always_comb begin
        st_d = st_q;
        if (hold) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CW'(LAST)) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
        st_d.rst.pll_n  = (st_d.cnt >= CW'(PLL_DLY));
        st_d.rst.chip_n = (st_d.cnt >= CW'(CHIP_DLY));
        st_d.rst.ip_n   = (st_d.cnt >= CW'(LAST));
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rst = st_q.rst;
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GLITCH_MAX  = 5,
    parameter int PLL_DLY     = 120,
    parameter int CHIP_DLY    = 3336,
    parameter int IP_TAIL     = 15
) (
    input  logic clk_ref,
    input  logic por_pin_n,
    output logic pll_rst_n,
    output logic chip_rst_n,
    output logic ip_rst_n
);
    logic     pin_sync_w;
    logic     hold_w;
    rst_vec_t rst_w;

    rs_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk_ref),
        .din  (por_pin_n),
        .dout (pin_sync_w)
    );

    rs_glitch_filter #(.GLITCH_MAX(GLITCH_MAX)) i_filter (
        .clk        (clk_ref),
        .pin_n_sync (pin_sync_w),
        .hold       (hold_w)
    );

    rs_release_timer #(
        .PLL_DLY  (PLL_DLY),
        .CHIP_DLY (CHIP_DLY),
        .IP_TAIL  (IP_TAIL)
    ) i_timer (
        .clk  (clk_ref),
        .hold (hold_w),
        .rst  (rst_w)
    );

    assign pll_rst_n  = rst_w.pll_n;
    assign chip_rst_n = rst_w.chip_n;
    assign ip_rst_n   = rst_w.ip_n;
endmodule

// File: rtl/rs_checker.sv
module rs_checker (
    input logic clk,
    input logic rst_hold,
    input logic pll_n,
    input logic chip_n,
    input logic ip_n
);
    AST_IP_NEEDS_CHIP: assert property (@(posedge clk) disable iff (rst_hold)
        ip_n |-> chip_n); // R7
    AST_CHIP_NEEDS_PLL: assert property (@(posedge clk) disable iff (rst_hold)
        chip_n |-> pll_n); // R7
    AST_FALL_TOGETHER: assert property (@(posedge clk) disable iff (rst_hold)
        $fell(pll_n) |-> (!chip_n && !ip_n)); // R3
    AST_CHIP_AFTER_PLL: assert property (@(posedge clk) disable iff (rst_hold)
        $rose(chip_n) |-> $past(pll_n)); // R5
    AST_IP_AFTER_CHIP: assert property (@(posedge clk) disable iff (rst_hold)
        $rose(ip_n) |-> $past(chip_n)); // R6
    AST_RELEASED_STAYS: assert property (@(posedge clk) disable iff (rst_hold)
        (!$past(rst_hold) && $past(ip_n)) |-> ip_n); // R9
endmodule

bind reset_sequencer rs_checker i_rs_checker (
    .clk      (clk_ref),
    .rst_hold (hold_w),
    .pll_n    (pll_rst_n),
    .chip_n   (chip_rst_n),
    .ip_n     (ip_rst_n)
);

// File: tb/test_reset_sequencer.sv
`timescale 1ns/1ps
module test_reset_sequencer;
    localparam int GM = 5;
    localparam int PD = 12;
    localparam int CD = 40;
    localparam int IT = 15;

    logic clk = 1'b0;
    logic pin = 1'b0;
    logic pll_n, chip_n, ip_n;

    int cyc = 0;
    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [2:0] vec;
        int         cyc;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    exp_t e;
    logic [2:0] prev = 3'b000;
    logic [2:0] cur;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    reset_sequencer #(
        .SYNC_STAGES (2),
        .GLITCH_MAX  (GM),
        .PLL_DLY     (PD),
        .CHIP_DLY    (CD),
        .IP_TAIL     (IT)
    ) i_reset_sequencer (
        .clk_ref    (clk),
        .por_pin_n  (pin),
        .pll_rst_n  (pll_n),
        .chip_rst_n (chip_n),
        .ip_rst_n   (ip_n)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(logic [2:0] v, int c, string r);
        exp_t x;
        x.vec = v; x.cyc = c; x.req = r;
        exp_q.push_back(x);
    endtask

    task automatic trim(int lim);
        exp_t keep[$];
        foreach (exp_q[i]) if (exp_q[i].cyc < lim) keep.push_back(exp_q[i]);
        exp_q = keep;
    endtask

    // Release expectations relative to the negedge where the pin rises.
    task automatic push_release(int base);
        push(3'b100, base + PD + 3, "R4");
        push(3'b110, base + CD + 3, "R5");
        push(3'b111, base + CD + IT + 3, "R6");
    endtask

    // Scoreboard monitor: every output change must match the queue head.
    always @(negedge clk) begin
        cur = {pll_n, chip_n, ip_n};
        if (cur !== prev) begin
            chk(!((cur[0] && !cur[1]) || (cur[1] && !cur[2])), "R7", "order vec", int'(cur), 0);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected change vec", int'(cur), int'(prev));
            end else begin
                e = exp_q.pop_front();
                chk(cur == e.vec, e.req, "vector", int'(cur), int'(e.vec));
                chk(cyc == e.cyc, e.req, "cycle", cyc, e.cyc);
            end
            prev = cur;
        end
    end

    task automatic low_pulse(int n, string req);
        int base;
        bit acc;
        acc = (n > GM);
        @(negedge clk);
        pin = 1'b0;
        base = cyc;
        if (acc) begin
            trim(base + GM + 4);
            if ({pll_n, chip_n, ip_n} != 3'b000) push(3'b000, base + GM + 4, req);
        end
        repeat (n) @(negedge clk);
        pin = 1'b1;
        if (acc) push_release(cyc);
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
        finish_run();
    end

    initial begin
        // R1: reset state while the pin is low from time zero
        repeat (20) @(negedge clk);
        chk({pll_n, chip_n, ip_n} == 3'b000, "R1", "held vec", int'({pll_n, chip_n, ip_n}), 0);
        @(negedge clk);
        pin = 1'b1;
        push_release(cyc);
        wait_idle();

        // R2: glitch of exactly GM sampled lows is ignored
        low_pulse(GM, "R2");
        repeat (30) @(negedge clk);
        chk({pll_n, chip_n, ip_n} == 3'b111, "R2", "after glitch vec", int'({pll_n, chip_n, ip_n}), 7);

        // R3: GM+1 lows accepted, then full release
        low_pulse(GM + 1, "R3");
        wait_idle();

        // R8: accepted low after PLL release, before chip release
        low_pulse(10, "R3");
        repeat (PD + 8) @(negedge clk);
        low_pulse(8, "R8");
        wait_idle();
        chk({pll_n, chip_n, ip_n} == 3'b111, "R8", "restart end vec", int'({pll_n, chip_n, ip_n}), 7);

        // R2: glitch mid-sequence does not move the timing
        low_pulse(10, "R3");
        repeat (PD + 5) @(negedge clk);
        low_pulse(GM, "R2");
        wait_idle();

        // Long low, then release
        low_pulse(50, "R3");
        wait_idle();

        // R9: released outputs stay high
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if ({pll_n, chip_n, ip_n} != 3'b111) begin
                chk(1'b0, "R9", "stay vec", int'({pll_n, chip_n, ip_n}), 7);
                break;
            end
        end
        chk({pll_n, chip_n, ip_n} == 3'b111, "R9", "final vec", int'({pll_n, chip_n, ip_n}), 7);
        chk(exp_q.size() == 0, "R6", "pending events", exp_q.size(), 0);
        finish_run();
    end
endmodule